// File: doc/BRIEF.md
# Arithmetic Shift Register

This block holds a 64-bit word that changes only on the rising clock edge. On each edge it can clear the word, take a new word in parallel from the data input, shift the stored word left or right by one bit or by a whole byte, or keep the word as it is. Left shifts bring zeros in at the bottom. Right shifts are arithmetic: copies of the current top bit fill the vacated upper positions, so the stored value keeps its two's-complement sign.

The usual use is as a small datapath stage. A controller loads a signed operand and then applies a series of single-cycle scaling steps. Each step multiplies the operand by 2 or 256, or divides it by 2 or 256 with the result rounded toward minus infinity. The 2-bit amount code sets both the direction and the distance of each step.

Top module: `asr_reg`

## Requirements
- R1: When `rst` is high at a rising edge, `q_o` becomes all zeros on that edge, whatever the other inputs are.
- R2: When `rst` is low and `load_i` is high at a rising edge, `q_o` takes the value of `data_i` on that edge.
- R3: When `load_i` and `shift_en_i` are both high, the load wins and no shift takes place.
- R4: When `rst`, `load_i` and `shift_en_i` are all low at an edge, `q_o` keeps its value.
- R5: Amount code 2'b00 with `shift_en_i` high shifts the word left by one bit, and bit 0 becomes 0.
- R6: Amount code 2'b01 with `shift_en_i` high shifts the word left by eight bits, and bits 7..0 become 0.
- R7: Amount code 2'b10 with `shift_en_i` high shifts the word right by one bit, and bit 63 keeps its old value.
- R8: Amount code 2'b11 with `shift_en_i` high shifts the word right by eight bits. Bits 63..56 become all ones when the old bit 63 was 1, and all zeros when it was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| load_i | input | 1 | Parallel load strobe |
| data_i | input | 64 | Word to load |
| shift_en_i | input | 1 | Shift strobe |
| amount_i | input | 2 | Shift code: 00 left 1, 01 left 8, 10 right 1, 11 right 8 |
| q_o | output | 64 | Stored word |

## Verification
The bench targets right shifts of negative words. A logical shift would put zeros into bits 63..56 or bit 63, and the bench detects this because the expected value has ones there. It also checks the low byte after a left shift by eight, where a rotate or a wrong fill would leave stray bits. Cycles that assert load and shift together catch an inverted priority, which would show the shifted old word instead of the new data. Idle cycles placed between operations expose a register that keeps shifting when the strobe is low.

// File: rtl/asr_pkg.sv
package asr_pkg;

    localparam int unsigned WORD_W  = 64;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned AMT_W   = 2;
    localparam int unsigned N_DIST  = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [AMT_W-1:0] {
        SH_LEFT_1  = 2'b00,
        SH_LEFT_8  = 2'b01,
        SH_RIGHT_1 = 2'b10,
        SH_RIGHT_8 = 2'b11
    } shcode_e;

    typedef struct packed {
        logic    clear;
        logic    load;
        logic    shift;
        shcode_e code;
    } ctrl_t;

    // bit 1 of the code selects the direction, bit 0 selects the distance
    function automatic logic code_is_right(shcode_e c);
        return c[1];
    endfunction

    function automatic logic code_is_long(shcode_e c);
        return c[0];
    endfunction

    // distance for index k: 0 -> single bit, 1 -> a whole byte
    function automatic int unsigned dist_of(int unsigned k);
        return (k == 0) ? 1 : BYTE_W;
    endfunction

endpackage

// File: rtl/asr_shifter.sv
module asr_shifter #(
    parameter int unsigned W    = 64,
    parameter int unsigned DIST = 1
) (
    input  logic [W-1:0] d_i,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o
);
    assign left_o  = d_i << DIST;
    assign right_o = $signed(d_i) >>> DIST;

    always_comb begin
        assert_sign_kept_R7: assert (right_o[W-1] == d_i[W-1])
            else $error("arithmetic right shift changed the sign bit");
        assert_zero_fill_R5: assert (left_o[DIST-1:0] == '0)
            else $error("left shift brought in a non-zero bit");
    end
endmodule

// File: rtl/asr_shift_bank.sv
module asr_shift_bank
    import asr_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] d_i,
    input  shcode_e      code_i,
    output logic [W-1:0] shifted_o
);
    logic [W-1:0] lefts  [N_DIST];
    logic [W-1:0] rights [N_DIST];

    for (genvar k = 0; k < N_DIST; k++) begin : g_dist
        asr_shifter #(
            .W    (W),
            .DIST (dist_of(k))
        ) u_sh (
            .d_i     (d_i),
            .left_o  (lefts[k]),
            .right_o (rights[k])
        );
    end

    always_comb begin
        if (code_is_right(code_i))
            shifted_o = code_is_long(code_i) ? rights[1] : rights[0];
        else
            shifted_o = code_is_long(code_i) ? lefts[1] : lefts[0];
    end
endmodule

// File: rtl/asr_next_state.sv
module asr_next_state
    import asr_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  ctrl_t        ctrl_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] shifted_i,
    output logic [W-1:0] next_o
);
    always_comb begin
        if (ctrl_i.clear)
            next_o = '0;
        else if (ctrl_i.load)
            next_o = data_i;
        else if (ctrl_i.shift)
            next_o = shifted_i;
        else
            next_o = cur_i;
    end
endmodule

// File: rtl/asr_reg.sv
module asr_reg
    import asr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              shift_en_i,
    input  logic [AMT_W-1:0]  amount_i,
    output logic [WORD_W-1:0] q_o
);
    ctrl_t ctrl;
    word_t q_r;
    word_t shifted;
    word_t q_next;

    assign ctrl.clear = rst;
    assign ctrl.load  = load_i;
    assign ctrl.shift = shift_en_i;
    assign ctrl.code  = shcode_e'(amount_i);

    asr_shift_bank #(.W(WORD_W)) u_bank (
        .d_i       (q_r),
        .code_i    (ctrl.code),
        .shifted_o (shifted)
    );

    asr_next_state #(.W(WORD_W)) u_next (
        .ctrl_i    (ctrl),
        .cur_i     (q_r),
        .data_i    (data_i),
        .shifted_i (shifted),
        .next_o    (q_next)
    );

    always_ff @(posedge clk) begin
        q_r <= q_next;
    end

    assign q_o = q_r;

    assert_clear_R1: assert property (@(posedge clk)
        rst |=> q_o == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> q_o == $past(data_i));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && shift_en_i) |=> q_o == $past(data_i));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !shift_en_i) |=> $stable(q_o));

    assert_left8_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && shift_en_i && amount_i == 2'b01)
        |=> q_o == {$past(q_o[WORD_W-BYTE_W-1:0]), {BYTE_W{1'b0}}});

    assert_right1_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && shift_en_i && amount_i == 2'b10)
        |=> q_o == {$past(q_o[WORD_W-1]), $past(q_o[WORD_W-1:1])});

    assert_right8_R8: assert property (@(posedge clk) disable iff (rst)
        (!load_i && shift_en_i && amount_i == 2'b11)
        |=> q_o[WORD_W-1:WORD_W-BYTE_W] == {BYTE_W{$past(q_o[WORD_W-1])}});
endmodule

// File: tb/test_asr_reg.sv
module test_asr_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_i;
    logic [63:0] data_i;
    logic        shift_en_i;
    logic [1:0]  amount_i;
    logic [63:0] q_o;

    int n_vec  = 0;
    int n_fail = 0;
    logic [63:0] model;

    always #2 clk = ~clk;

    asr_reg i_asr_reg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .data_i     (data_i),
        .shift_en_i (shift_en_i),
        .amount_i   (amount_i),
        .q_o        (q_o)
    );

    function automatic logic [63:0] ref_shift(logic [63:0] v, logic [1:0] c);
        logic [63:0] r;
        int d = c[0] ? 8 : 1;
        for (int i = 0; i < 64; i++) begin
            if (c[1]) r[i] = (i + d < 64) ? v[i+d] : v[63];
            else      r[i] = (i >= d) ? v[i-d] : 1'b0;
        end
        return r;
    endfunction

    function automatic string tag_of(logic r, logic l, logic s, logic [1:0] c);
        if (r) return "R1";
        if (l && s) return "R3";
        if (l) return "R2";
        if (!s) return "R4";
        case (c)
            2'b00: return "R5";
            2'b01: return "R6";
            2'b10: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic step(input logic r, input logic l, input logic [63:0] d,
                        input logic s, input logic [1:0] c);
        string tag;
        rst = r; load_i = l; data_i = d; shift_en_i = s; amount_i = c;
        tag = tag_of(r, l, s, c);
        @(posedge clk);
        if (r)      model = '0;
        else if (l) model = d;
        else if (s) model = ref_shift(model, c);
        @(negedge clk);
        n_vec++;
        if (q_o !== model) begin
            n_fail++;
            $display("FAIL %s: q_o=%h expected %h", tag, q_o, model);
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: q_o=%h expected completion", q_o);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; load_i = 1'b0; data_i = '0; shift_en_i = 1'b0; amount_i = 2'b00;
        @(negedge clk);
        // R1: clear with load and shift also requested
        step(1, 1, 64'hFFFF_0000_1234_5678, 1, 2'b11);
        // R2: load a negative word
        step(0, 1, 64'h8123_4567_89AB_CDEF, 0, 2'b00);
        // R8: byte right shift of negative word fills ones
        step(0, 0, '0, 1, 2'b11);
        // R4: idle holds
        step(0, 0, 64'hDEAD_BEEF_DEAD_BEEF, 0, 2'b11);
        // R7: bit right shift of negative word
        step(0, 0, '0, 1, 2'b10);
        // R2 then R8 on non-negative word
        step(0, 1, 64'h7F00_FF00_0000_00FF, 0, 2'b00);
        step(0, 0, '0, 1, 2'b11);
        step(0, 0, '0, 1, 2'b10);
        // R6: byte left shift, low byte zero
        step(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b00);
        step(0, 0, '0, 1, 2'b01);
        // R5: bit left shift
        step(0, 0, '0, 1, 2'b00);
        // R3: load and shift together
        step(0, 1, 64'h0102_0304_0506_0708, 1, 2'b01);
        step(0, 1, 64'hF000_0000_0000_0001, 1, 2'b10);
        step(0, 0, '0, 0, 2'b00);
        // mixed stimulus
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] k = $urandom;
            step(k[7:0] == 8'd0, k[10:8] == 3'd0, {$urandom, $urandom},
                 k[12:11] != 2'd0, k[14:13]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule